// File: doc/BRIEF.md
# Banked CPU register file with exchange

This block is the programmer-visible register storage of an 8-bit processor core. It holds the accumulator A and flags F, and six general bytes B, C, D, E, H and L that also pair up as BC, DE and HL. All eight of these bytes have a second, shadow copy. It also holds two 16-bit index registers, a stack pointer, an interrupt-vector byte I and a refresh counter R. The decoder reads one byte and one pair every cycle through combinational ports. It writes one byte and one pair per clock edge.

Two exchange commands flip which copy is live. One command covers the A/F group. The other covers the BC/DE/HL group. Each command takes a single cycle and moves no data. The refresh counter advances on each opcode or prefix fetch strobe. The block always drives a 16-bit interrupt table address made from I and the byte offered by the interrupting device. In interrupt modes 0 and 1 this address is simply ignored, and I serves as an ordinary byte register.

Top module: `dual_bank_regfile`

## Requirements
- R1: Byte codes select registers as follows: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 F, 7 A, 8 IXH, 9 IXL, 10 IYH, 11 IYL, 12 I, 13 R, 14 SP high, 15 SP low. A byte write takes effect at the next rising clock edge. `rd_data` shows the selected byte combinationally.
- R2: Pair codes 0, 1 and 2 select BC, DE and HL. The first-named register is the upper byte. Pair reads and writes match the byte contents of the two registers.
- R3: Pair code 3 is AF, with A as the upper byte and F as the lower byte. F stores all eight bits exactly as written. The bit order from 7 down to 0 is S, Z, spare, H, spare, P/V, N, C.
- R4: A pulse on `ex_af` swaps the live and shadow A/F pair at the clock edge. BC, DE and HL are unchanged.
- R5: A pulse on `ex_gen` swaps BC, DE and HL with their shadows at the clock edge. A and F are unchanged.
- R6: Both exchanges may be given in the same cycle, and both then take effect. A write issued in the same cycle as an exchange lands in the copy that was live before the exchange.
- R7: Pair codes 4, 5 and 6 select IX, IY and SP. Their halves can also be read and written through the byte codes in R1.
- R8: Each cycle with `fetch` high increments the low REFRESH_W bits of R, wrapping within that field. The upper bits of R keep the value last written. With the defaults, 0x7F steps to 0x00 and 0x80 plus 130 fetches gives 0x82.
- R9: A byte write to R in the same cycle as `fetch` stores the written value, and the increment is dropped.
- R10: `vec_addr` always equals I in the upper byte and `vec_byte` in the lower byte. I changes only on a byte write to code 12.
- R11: Pair code 7 reads as zero. A pair write to code 7 changes no register.
- R12: When a byte write and a pair write target the same byte in the same cycle, the pair write's value is stored.
- R13: Reset clears every register, both copies of A through L, and both bank selects to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel | input | 4 | Byte read code |
| rd_data | output | DATA_W | Byte read data |
| prd_sel | input | 3 | Pair read code |
| prd_data | output | 2*DATA_W | Pair read data |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 4 | Byte write code |
| wr_data | input | DATA_W | Byte write data |
| pwr_en | input | 1 | Pair write enable |
| pwr_sel | input | 3 | Pair write code |
| pwr_data | input | 2*DATA_W | Pair write data |
| ex_af | input | 1 | Exchange live/shadow A and F |
| ex_gen | input | 1 | Exchange live/shadow BC, DE, HL |
| fetch | input | 1 | Opcode or prefix fetch strobe |
| vec_byte | input | DATA_W | Byte supplied by interrupting device |
| vec_addr | output | 2*DATA_W | Interrupt table address |

## Verification
The bench builds the block with its defaults: DATA_W of 8 and REFRESH_W of 7. Because the count field is narrower than the byte, these values select the variant of the refresh counter that keeps the top bit. They also make the 7-bit wrap reachable after 128 fetch strobes, so the run shows both the wrap and the preserved bit 7. A full-width counter is not built. The byte and pair widths match the 16-bit table address, so the vector check covers the real layout.

// File: rtl/drf_pkg.sv
package drf_pkg;
   localparam int SLOT_W  = 4;
   localparam int NSLOT   = 16;
   localparam int NBANKED = 8;
   localparam int NAUX    = NSLOT - NBANKED;
   localparam int PAIR_W  = 3;

   typedef logic [SLOT_W-1:0] slot_t;
   typedef logic [PAIR_W-1:0] pair_t;

   // byte slot numbering; 0..7 live in the two banks
   localparam slot_t SL_B   = 4'd0;
   localparam slot_t SL_C   = 4'd1;
   localparam slot_t SL_D   = 4'd2;
   localparam slot_t SL_E   = 4'd3;
   localparam slot_t SL_H   = 4'd4;
   localparam slot_t SL_L   = 4'd5;
   localparam slot_t SL_F   = 4'd6;
   localparam slot_t SL_A   = 4'd7;
   localparam slot_t SL_IXH = 4'd8;
   localparam slot_t SL_IXL = 4'd9;
   localparam slot_t SL_IYH = 4'd10;
   localparam slot_t SL_IYL = 4'd11;
   localparam slot_t SL_I   = 4'd12;
   localparam slot_t SL_R   = 4'd13;
   localparam slot_t SL_SPH = 4'd14;
   localparam slot_t SL_SPL = 4'd15;

   localparam pair_t PR_BC   = 3'd0;
   localparam pair_t PR_DE   = 3'd1;
   localparam pair_t PR_HL   = 3'd2;
   localparam pair_t PR_AF   = 3'd3;
   localparam pair_t PR_IX   = 3'd4;
   localparam pair_t PR_IY   = 3'd5;
   localparam pair_t PR_SP   = 3'd6;
   localparam pair_t PR_NONE = 3'd7;

   function automatic slot_t pair_hi(input pair_t p);
      case (p)
         PR_BC:   return SL_B;
         PR_DE:   return SL_D;
         PR_HL:   return SL_H;
         PR_AF:   return SL_A;
         PR_IX:   return SL_IXH;
         PR_IY:   return SL_IYH;
         default: return SL_SPH;
      endcase
   endfunction

   function automatic slot_t pair_lo(input pair_t p);
      case (p)
         PR_BC:   return SL_C;
         PR_DE:   return SL_E;
         PR_HL:   return SL_L;
         PR_AF:   return SL_F;
         PR_IX:   return SL_IXL;
         PR_IY:   return SL_IYL;
         default: return SL_SPL;
      endcase
   endfunction

   function automatic logic pair_ok(input pair_t p);
      return p != PR_NONE;
   endfunction

   // slot belongs to the accumulator/flags exchange group
   function automatic logic in_af_group(input int s);
      return (s == int'(SL_F)) || (s == int'(SL_A));
   endfunction
endpackage

// File: rtl/drf_bank.sv
module drf_bank #(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SLOTS-1:0]              we,
   input  logic [SLOTS-1:0][DATA_W-1:0]  wd,
   output logic [SLOTS-1:0][DATA_W-1:0]  q
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[s] <= '0;
         else if (we[s])
            q[s] <= wd[s];
      end
   end
endmodule

// File: rtl/drf_aux.sv
module drf_aux #(
   parameter int DATA_W    = 8,
   parameter int SLOTS     = 8,
   parameter int R_LOCAL   = 5,
   parameter int REFRESH_W = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SLOTS-1:0]              we,
   input  logic [SLOTS-1:0][DATA_W-1:0]  wd,
   input  logic                          fetch,
   output logic [SLOTS-1:0][DATA_W-1:0]  q
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s == R_LOCAL) begin : g_refresh
         logic [DATA_W-1:0] step;
         if (REFRESH_W == DATA_W) begin : g_full
            assign step = q[s] + DATA_W'(1);
         end else begin : g_part
            assign step = {q[s][DATA_W-1:REFRESH_W],
                           q[s][REFRESH_W-1:0] + REFRESH_W'(1)};
         end
         always_ff @(posedge clk) begin
            if (!rst_n)
               q[s] <= '0;
            else if (we[s])
               q[s] <= wd[s];
            else if (fetch)
               q[s] <= step;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               q[s] <= '0;
            else if (we[s])
               q[s] <= wd[s];
         end
      end
   end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
   import drf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REFRESH_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            rd_sel,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [2:0]            prd_sel,
   output logic [2*DATA_W-1:0]   prd_data,
   input  logic                  wr_en,
   input  logic [3:0]            wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  pwr_en,
   input  logic [2:0]            pwr_sel,
   input  logic [2*DATA_W-1:0]   pwr_data,
   input  logic                  ex_af,
   input  logic                  ex_gen,
   input  logic                  fetch,
   input  logic [DATA_W-1:0]     vec_byte,
   output logic [2*DATA_W-1:0]   vec_addr
);
   localparam int PW      = 2 * DATA_W;
   localparam int NBANKS  = 2;
   localparam int R_LOCAL = int'(SL_R) - NBANKED;
   localparam int I_LOCAL = int'(SL_I) - NBANKED;

   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end
   if (REFRESH_W < 1 || REFRESH_W > DATA_W) begin : g_bad_r
      $error("REFRESH_W must lie in 1..DATA_W");
   end

   logic sel_af_q, sel_gp_q;
   logic [NSLOT-1:0]              slot_we;
   logic [NSLOT-1:0][DATA_W-1:0]  slot_wd;
   logic [NSLOT-1:0][DATA_W-1:0]  slot_val;
   logic [NBANKS-1:0][NBANKED-1:0]             bank_we;
   logic [NBANKS-1:0][NBANKED-1:0][DATA_W-1:0] bank_q;
   logic [NAUX-1:0][DATA_W-1:0]   aux_q;
   logic [DATA_W-1:0]             r_val, i_val;

   // write merge: pair write data takes precedence on a shared byte
   always_comb begin
      for (int s = 0; s < NSLOT; s++) begin
         logic byte_hit, hi_hit, lo_hit;
         byte_hit   = wr_en && (wr_sel == slot_t'(s));
         hi_hit     = pwr_en && pair_ok(pwr_sel) && (pair_hi(pwr_sel) == slot_t'(s));
         lo_hit     = pwr_en && pair_ok(pwr_sel) && (pair_lo(pwr_sel) == slot_t'(s));
         slot_we[s] = byte_hit || hi_hit || lo_hit;
         if (hi_hit)
            slot_wd[s] = pwr_data[PW-1:DATA_W];
         else if (lo_hit)
            slot_wd[s] = pwr_data[DATA_W-1:0];
         else
            slot_wd[s] = wr_data;
      end
   end

   // route banked writes to the copy that is live this cycle
   always_comb begin
      for (int b = 0; b < NBANKS; b++) begin
         for (int s = 0; s < NBANKED; s++) begin
            logic live;
            live = in_af_group(s) ? sel_af_q : sel_gp_q;
            bank_we[b][s] = slot_we[s] && (live == 1'(b));
         end
      end
   end

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      drf_bank #(.DATA_W(DATA_W), .SLOTS(NBANKED)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (bank_we[b]),
         .wd    (slot_wd[NBANKED-1:0]),
         .q     (bank_q[b])
      );
   end

   drf_aux #(
      .DATA_W    (DATA_W),
      .SLOTS     (NAUX),
      .R_LOCAL   (R_LOCAL),
      .REFRESH_W (REFRESH_W)
   ) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (slot_we[NSLOT-1:NBANKED]),
      .wd    (slot_wd[NSLOT-1:NBANKED]),
      .fetch (fetch),
      .q     (aux_q)
   );

   // bank selects: toggling replaces any data movement
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_af_q <= 1'b0;
         sel_gp_q <= 1'b0;
      end else begin
         if (ex_af)  sel_af_q <= ~sel_af_q;
         if (ex_gen) sel_gp_q <= ~sel_gp_q;
      end
   end

   always_comb begin
      for (int s = 0; s < NSLOT; s++) begin
         if (s < NBANKED)
            slot_val[s] = bank_q[in_af_group(s) ? sel_af_q : sel_gp_q][s];
         else
            slot_val[s] = aux_q[s - NBANKED];
      end
   end

   assign r_val    = aux_q[R_LOCAL];
   assign i_val    = aux_q[I_LOCAL];
   assign rd_data  = slot_val[rd_sel];
   assign prd_data = pair_ok(prd_sel)
                   ? {slot_val[pair_hi(prd_sel)], slot_val[pair_lo(prd_sel)]}
                   : '0;
   assign vec_addr = {i_val, vec_byte};
endmodule

// File: rtl/drf_chk.sv
module drf_chk
   import drf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REFRESH_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ex_af,
   input logic              ex_gen,
   input logic              sel_af_q,
   input logic              sel_gp_q,
   input logic              fetch,
   input logic              wr_en,
   input logic [3:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] r_val,
   input logic [DATA_W-1:0] i_val
);
   logic r_wr, i_wr;
   assign r_wr = wr_en && (wr_sel == SL_R);
   assign i_wr = wr_en && (wr_sel == SL_I);

   // R4
   af_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ex_af |=> sel_af_q != $past(sel_af_q));
   // R4
   af_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_af |=> sel_af_q == $past(sel_af_q));
   // R5
   gp_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ex_gen |=> sel_gp_q != $past(sel_gp_q));
   // R5
   gp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_gen |=> sel_gp_q == $past(sel_gp_q));
   // R8
   r_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && !r_wr) |=>
         r_val[REFRESH_W-1:0] == $past(r_val[REFRESH_W-1:0]) + REFRESH_W'(1));
   // R9
   r_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_wr |=> r_val == $past(wr_data));
   // R10
   i_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !i_wr |=> $stable(i_val));

   if (REFRESH_W < DATA_W) begin : g_top
      // R8
      r_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !r_wr |=> $stable(r_val[DATA_W-1:REFRESH_W]));
   end
endmodule

bind dual_bank_regfile drf_chk #(.DATA_W(DATA_W), .REFRESH_W(REFRESH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ex_af    (ex_af),
   .ex_gen   (ex_gen),
   .sel_af_q (sel_af_q),
   .sel_gp_q (sel_gp_q),
   .fetch    (fetch),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .r_val    (r_val),
   .i_val    (i_val)
);

// File: tb/dual_bank_regfile_bench.sv
module dual_bank_regfile_bench;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [3:0]    rd_sel;
   logic [DW-1:0] rd_data;
   logic [2:0]    prd_sel;
   logic [2*DW-1:0] prd_data;
   logic          wr_en;
   logic [3:0]    wr_sel;
   logic [DW-1:0] wr_data;
   logic          pwr_en;
   logic [2:0]    pwr_sel;
   logic [2*DW-1:0] pwr_data;
   logic          ex_af, ex_gen, fetch;
   logic [DW-1:0] vec_byte;
   logic [2*DW-1:0] vec_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dual_bank_regfile u_dual_bank_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .prd_sel(prd_sel), .prd_data(prd_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pwr_en(pwr_en), .pwr_sel(pwr_sel), .pwr_data(pwr_data),
      .ex_af(ex_af), .ex_gen(ex_gen), .fetch(fetch),
      .vec_byte(vec_byte), .vec_addr(vec_addr)
   );

   task automatic chk_byte(input logic [3:0] code, input logic [DW-1:0] exp, input string tag);
      rd_sel = code;
      #1;
      n_chk++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s byte code %0d: got %h expected %h", tag, code, rd_data, exp);
      end
   endtask

   task automatic chk_pair(input logic [2:0] code, input logic [2*DW-1:0] exp, input string tag);
      prd_sel = code;
      #1;
      n_chk++;
      if (prd_data !== exp) begin
         n_bad++;
         $display("FAIL %s pair code %0d: got %h expected %h", tag, code, prd_data, exp);
      end
   endtask

   task automatic wbyte(input logic [3:0] code, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = code; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wpair(input logic [2:0] code, input logic [2*DW-1:0] d);
      @(negedge clk);
      pwr_en = 1'b1; pwr_sel = code; pwr_data = d;
      @(negedge clk);
      pwr_en = 1'b0;
   endtask

   task automatic swap(input logic af, input logic gp);
      @(negedge clk);
      ex_af = af; ex_gen = gp;
      @(negedge clk);
      ex_af = 1'b0; ex_gen = 1'b0;
   endtask

   task automatic t_reset;
      for (int k = 0; k < 16; k++) chk_byte(4'(k), 8'h00, "R13 reset");
      vec_byte = 8'h5A;
      #1;
      n_chk++;
      if (vec_addr !== 16'h005A) begin
         n_bad++;
         $display("FAIL R13 reset vec: got %h expected 005a", vec_addr);
      end
   endtask

   task automatic t_bytes;
      wbyte(4'd0, 8'h12); wbyte(4'd1, 8'h34); wbyte(4'd2, 8'h56); wbyte(4'd3, 8'h78);
      wbyte(4'd4, 8'h9A); wbyte(4'd5, 8'hBC); wbyte(4'd7, 8'hDE); wbyte(4'd6, 8'hC5);
      chk_byte(4'd0, 8'h12, "R1 B");
      chk_byte(4'd5, 8'hBC, "R1 L");
      chk_byte(4'd7, 8'hDE, "R1 A");
      chk_pair(3'd0, 16'h1234, "R2 BC");
      chk_pair(3'd1, 16'h5678, "R2 DE");
      chk_pair(3'd2, 16'h9ABC, "R2 HL");
      chk_pair(3'd3, 16'hDEC5, "R3 AF");
      wpair(3'd1, 16'hFEDC);
      chk_byte(4'd2, 8'hFE, "R2 D from pair");
      chk_byte(4'd3, 8'hDC, "R2 E from pair");
      wpair(3'd1, 16'h5678);
   endtask

   task automatic t_ex_af;
      swap(1'b1, 1'b0);
      chk_pair(3'd3, 16'h0000, "R4 shadow AF");
      chk_pair(3'd0, 16'h1234, "R4 BC untouched");
      wbyte(4'd7, 8'h33);
      swap(1'b1, 1'b0);
      chk_pair(3'd3, 16'hDEC5, "R4 AF back");
      chk_pair(3'd2, 16'h9ABC, "R4 HL untouched");
   endtask

   task automatic t_exx;
      swap(1'b0, 1'b1);
      chk_pair(3'd0, 16'h0000, "R5 shadow BC");
      chk_pair(3'd2, 16'h0000, "R5 shadow HL");
      chk_pair(3'd3, 16'hDEC5, "R5 AF untouched");
      wpair(3'd2, 16'h4242);
      swap(1'b0, 1'b1);
      chk_pair(3'd2, 16'h9ABC, "R5 HL back");
      chk_pair(3'd1, 16'h5678, "R5 DE back");
   endtask

   task automatic t_both;
      @(negedge clk);
      ex_af = 1'b1; ex_gen = 1'b1;
      wr_en = 1'b1; wr_sel = 4'd7; wr_data = 8'h77;
      @(negedge clk);
      ex_af = 1'b0; ex_gen = 1'b0; wr_en = 1'b0;
      chk_byte(4'd7, 8'h33, "R6 shadow A live");
      chk_pair(3'd2, 16'h4242, "R6 shadow HL live");
      swap(1'b1, 1'b1);
      chk_pair(3'd3, 16'h77C5, "R6 write landed in old copy");
      chk_pair(3'd0, 16'h1234, "R6 BC back");
   endtask

   task automatic t_collide;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'h01;
      pwr_en = 1'b1; pwr_sel = 3'd0; pwr_data = 16'hABCD;
      @(negedge clk);
      wr_en = 1'b0; pwr_en = 1'b0;
      chk_pair(3'd0, 16'hABCD, "R12 pair wins");
   endtask

   task automatic t_null;
      wpair(3'd7, 16'hFFFF);
      chk_pair(3'd7, 16'h0000, "R11 null pair reads zero");
      chk_pair(3'd0, 16'hABCD, "R11 BC untouched");
      chk_pair(3'd3, 16'h77C5, "R11 AF untouched");
      chk_pair(3'd6, 16'h0000, "R11 SP untouched");
      chk_pair(3'd4, 16'h0000, "R11 IX untouched");
   endtask

   task automatic t_index;
      wpair(3'd4, 16'h1234);
      chk_byte(4'd8, 8'h12, "R7 IXH");
      chk_byte(4'd9, 8'h34, "R7 IXL");
      wbyte(4'd11, 8'h9F);
      wbyte(4'd10, 8'h8E);
      chk_pair(3'd5, 16'h8E9F, "R7 IY");
      wpair(3'd6, 16'hFFFE);
      chk_byte(4'd14, 8'hFF, "R7 SP high");
      chk_byte(4'd15, 8'hFE, "R7 SP low");
   endtask

   task automatic t_refresh;
      wbyte(4'd13, 8'h80);
      @(negedge clk);
      fetch = 1'b1;
      repeat (130) @(negedge clk);
      fetch = 1'b0;
      chk_byte(4'd13, 8'h82, "R8 wrap keeps bit 7");
      wbyte(4'd13, 8'h7F);
      @(negedge clk); fetch = 1'b1;
      @(negedge clk); fetch = 1'b0;
      chk_byte(4'd13, 8'h00, "R8 7f steps to 00");
   endtask

   task automatic t_rprio;
      @(negedge clk);
      fetch = 1'b1; wr_en = 1'b1; wr_sel = 4'd13; wr_data = 8'h40;
      @(negedge clk);
      fetch = 1'b0; wr_en = 1'b0;
      chk_byte(4'd13, 8'h40, "R9 write beats fetch");
   endtask

   task automatic t_vec;
      wbyte(4'd12, 8'hA5);
      vec_byte = 8'h3C;
      #1;
      n_chk++;
      if (vec_addr !== 16'hA53C) begin
         n_bad++;
         $display("FAIL R10 vec: got %h expected a53c", vec_addr);
      end
      chk_byte(4'd12, 8'hA5, "R10 I readback");
   endtask

   initial begin
      rst_n = 1'b0;
      rd_sel = '0; prd_sel = '0;
      wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      pwr_en = 1'b0; pwr_sel = '0; pwr_data = '0;
      ex_af = 1'b0; ex_gen = 1'b0; fetch = 1'b0; vec_byte = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bytes();
      t_ex_af();
      t_exx();
      t_both();
      t_collide();
      t_null();
      t_index();
      t_refresh();
      t_rprio();
      t_vec();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule